// File: doc/BRIEF.md
# Saturating Absolute and Negate Unit

This unit takes a packed vector of signed lanes and returns, for every lane, either the absolute value or the two's-complement negation. The one input that has no representable answer, the most negative value of the lane width, is clamped to the most positive value. Each such clamp is recorded in a sticky status bit that stays set until software clears it.

Operands arrive with a one-cycle valid strobe. The caller selects the lane width, whether the source is a 64-bit or a 128-bit register, whether the operation is scalar (lane 0 only) or vector, and whether to negate or take the absolute value. One cycle later the registered result appears with a one-cycle valid pulse. The lane count follows from the register width divided by the lane width. Bits above the processed data are returned as zero. A vector request with 64-bit lanes in a 64-bit register is rejected.

Top module: `sat_absneg_unit`

## Requirements
- R1: `size_code` 0, 1, 2 and 3 select signed lanes of 8, 16, 32 and 64 bits; lane i occupies bits [i*w +: w].
- R2: A vector operation processes 128/w lanes when `wide_mode`=1 and 64/w lanes when `wide_mode`=0; a scalar operation (`scalar_sel`=1) processes lane 0 only.
- R3: For any lane value other than the most negative, `neg_sel`=1 returns the exact negation and `neg_sel`=0 returns the exact absolute value.
- R4: A lane holding the most negative value yields the most positive value (for example 8'h80 gives 8'h7F) under both operations, and it sets the sticky bit.
- R5: The sticky bit is bit 27 of `status`, is OR-ed in and stays set across later operations that do not saturate; all other `status` bits read zero.
- R6: `clr_sticky` clears the sticky bit at the next clock edge; a saturation accepted in the same cycle wins and leaves the bit set.
- R7: In scalar mode and in 64-bit register mode, every `result` bit above the processed data is zero.
- R8: A vector request with `size_code`=3 and `wide_mode`=0 is illegal: `err` pulses with `out_valid`, `result` is zero and `status` is unchanged.
- R9: Synchronous active-high `rst` clears `status` and `out_valid`.
- R10: `out_valid` pulses for exactly one cycle, one cycle after `in_valid`; `result` and `err` are valid in that cycle, and `err` is never high without `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| src | input | 128 | Packed source lanes |
| size_code | input | 2 | Lane width code: 8 << size_code bits |
| wide_mode | input | 1 | 1: 128-bit register, 0: 64-bit register |
| scalar_sel | input | 1 | 1: scalar (lane 0 only), 0: vector |
| neg_sel | input | 1 | 1: negate, 0: absolute value |
| clr_sticky | input | 1 | Clears the sticky saturation bit |
| out_valid | output | 1 | One-cycle result strobe |
| result | output | 128 | Packed result |
| err | output | 1 | Illegal size/mode combination, valid with out_valid |
| status | output | 32 | Status read port, sticky saturation bit at 27 |

## Verification
Every result, error flag and status update is due at the first clock edge after the cycle in which `in_valid` is sampled. A clear takes effect at the first edge after `clr_sticky` is sampled. The driver changes inputs on the falling edge and pushes the expected item at that moment. The monitor samples 2 ns after each rising edge, so an item pushed in cycle k is compared against the outputs of cycle k+1. A raised `out_valid` with an empty queue, or a missing `out_valid` with a pending item, counts as a failure. The clear checks read `status` one full cycle after the clear request.

// File: rtl/sat_pkg.sv
package sat_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } elem_size_e;

    localparam int NUM_SIZES  = 4;
    localparam int BASE_LANE  = 8;

    function automatic int lane_bits(input int code);
        return BASE_LANE << code;
    endfunction

endpackage

// File: rtl/sat_lane.sv
// One signed lane: absolute value or negation with clamp of the most negative value.
module sat_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic         neg,
    output logic [W-1:0] y,
    output logic         sat
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

    always_comb begin
        sat = (x == MOST_NEG);
        if (sat) begin
            y = MOST_POS;
        end else if (neg || x[W-1]) begin
            y = (~x) + 1'b1;
        end else begin
            y = x;
        end
    end
endmodule

// File: rtl/sat_bank.sv
// All lanes of one width; lanes at or above act_cnt are zeroed and do not flag.
module sat_bank #(
    parameter int DATA_W = 128,
    parameter int LANE_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic [DATA_W-1:0] data,
    input  logic              neg,
    input  logic [CNT_W-1:0]  act_cnt,
    output logic [DATA_W-1:0] res,
    output logic              sat_any
);
    localparam int N = DATA_W / LANE_W;

    logic [N-1:0] sat_v;

    for (genvar i = 0; i < N; i++) begin : g_lane
        localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
        logic [LANE_W-1:0] y_l;
        logic              s_l;
        logic              on_l;

        sat_lane #(.W(LANE_W)) u_lane (
            .x   (data[i*LANE_W +: LANE_W]),
            .neg (neg),
            .y   (y_l),
            .sat (s_l)
        );

        assign on_l                     = (IDX < act_cnt);
        assign res[i*LANE_W +: LANE_W]  = on_l ? y_l : '0;
        assign sat_v[i]                 = on_l & s_l;
    end

    assign sat_any = |sat_v;
endmodule

// File: rtl/sat_absneg_unit.sv
module sat_absneg_unit
    import sat_pkg::*;
#(
    parameter int DATA_W     = 128,
    parameter int STATUS_W   = 32,
    parameter int STICKY_BIT = 27
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   src,
    input  logic [1:0]          size_code,
    input  logic                wide_mode,
    input  logic                scalar_sel,
    input  logic                neg_sel,
    input  logic                clr_sticky,
    output logic                out_valid,
    output logic [DATA_W-1:0]   result,
    output logic                err,
    output logic [STATUS_W-1:0] status
);
    localparam int CNT_W = $clog2(DATA_W / BASE_LANE) + 1;
    localparam logic [CNT_W-1:0] CNT_WIDE   = CNT_W'(DATA_W / BASE_LANE);
    localparam logic [CNT_W-1:0] CNT_NARROW = CNT_W'(DATA_W / (2 * BASE_LANE));

    typedef struct packed {
        logic              vld;
        logic              err;
        logic [DATA_W-1:0] res;
        logic              sticky;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0] bank_res [NUM_SIZES];
    logic              bank_sat [NUM_SIZES];
    logic [CNT_W-1:0]  full_cnt;
    logic [CNT_W-1:0]  act_cnt;
    logic              bad_req;

    always_comb begin
        full_cnt = wide_mode ? CNT_WIDE : CNT_NARROW;
        act_cnt  = scalar_sel ? CNT_W'(1) : (full_cnt >> size_code);
        bad_req  = !scalar_sel && !wide_mode && (size_code == SZ_DWORD);
    end

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_bank
        sat_bank #(
            .DATA_W (DATA_W),
            .LANE_W (lane_bits(s)),
            .CNT_W  (CNT_W)
        ) u_bank (
            .data    (src),
            .neg     (neg_sel),
            .act_cnt (act_cnt),
            .res     (bank_res[s]),
            .sat_any (bank_sat[s])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.err = in_valid && bad_req;
        if (in_valid) begin
            st_d.res = bad_req ? '0 : bank_res[size_code];
        end
        st_d.sticky = (st_q.sticky && !clr_sticky)
                    || (in_valid && !bad_req && bank_sat[size_code]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        out_valid          = st_q.vld;
        err                = st_q.err;
        result             = st_q.res;
        status             = '0;
        status[STICKY_BIT] = st_q.sticky;
    end
endmodule

// File: rtl/sat_absneg_chk.sv
module sat_absneg_chk #(
    parameter int DATA_W     = 128,
    parameter int STATUS_W   = 32,
    parameter int STICKY_BIT = 27
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [DATA_W-1:0]   src,
    input logic [1:0]          size_code,
    input logic                wide_mode,
    input logic                scalar_sel,
    input logic                clr_sticky,
    input logic                out_valid,
    input logic [DATA_W-1:0]   result,
    input logic                err,
    input logic [STATUS_W-1:0] status
);
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r10_err_needs_valid: assert property (@(posedge clk) disable iff (rst)
        err |-> out_valid);

    a_r5_sticky_holds: assert property (@(posedge clk) disable iff (rst)
        (status[STICKY_BIT] && !clr_sticky) |=> status[STICKY_BIT]);

    a_r6_clear_works: assert property (@(posedge clk) disable iff (rst)
        (clr_sticky && !in_valid) |=> !status[STICKY_BIT]);

    a_r8_illegal_rejected: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !scalar_sel && !wide_mode && size_code == 2'd3 && !clr_sticky)
        |=> (err && $stable(status) && result == '0));

    a_r7_scalar_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && scalar_sel && size_code == 2'd0) |=> (result[DATA_W-1:8] == '0));

    a_r4_min_clamps: assert property (@(posedge clk) disable iff (rst)
        (in_valid && scalar_sel && size_code == 2'd0 && src[7:0] == 8'h80)
        |=> (result[7:0] == 8'h7F && status[STICKY_BIT]));

    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && status == '0));
endmodule

bind sat_absneg_unit sat_absneg_chk #(
    .DATA_W     (DATA_W),
    .STATUS_W   (STATUS_W),
    .STICKY_BIT (STICKY_BIT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .src        (src),
    .size_code  (size_code),
    .wide_mode  (wide_mode),
    .scalar_sel (scalar_sel),
    .clr_sticky (clr_sticky),
    .out_valid  (out_valid),
    .result     (result),
    .err        (err),
    .status     (status)
);

// File: tb/sat_absneg_unit_test.sv
module sat_absneg_unit_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] src = '0;
    logic [1:0]   size_code = '0;
    logic         wide_mode = 1'b0;
    logic         scalar_sel = 1'b0;
    logic         neg_sel = 1'b0;
    logic         clr_sticky = 1'b0;
    logic         out_valid;
    logic [127:0] result;
    logic         err;
    logic [31:0]  status;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit model_sticky = 0;

    logic [127:0] q_res [$];
    bit           q_err [$];
    logic [31:0]  q_st  [$];
    string        q_tag [$];

    sat_absneg_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src(src),
        .size_code(size_code), .wide_mode(wide_mode), .scalar_sel(scalar_sel),
        .neg_sel(neg_sel), .clr_sticky(clr_sticky), .out_valid(out_valid),
        .result(result), .err(err), .status(status)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model(input logic [127:0] s, input int sz, input bit wide,
                                  input bit sc, input bit ng,
                                  output logic [127:0] r, output bit sat, output bit bad);
        int lw;
        int n;
        logic [63:0] m, e, minv, rv;
        longint v;
        lw  = 8 << sz;
        r   = '0;
        sat = 0;
        bad = !sc && !wide && (sz == 3);
        if (bad) return;
        n    = sc ? 1 : ((wide ? 16 : 8) >> sz);
        m    = (lw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << lw) - 64'd1);
        minv = 64'd1 << (lw - 1);
        for (int i = 0; i < n; i++) begin
            e = 64'(s >> (i * lw)) & m;
            if (e == minv) begin
                rv  = minv - 64'd1;
                sat = 1;
            end else begin
                v = longint'(e << (64 - lw)) >>> (64 - lw);
                if (ng || v < 0) v = -v;
                rv = 64'(v) & m;
            end
            r = r | (128'(rv) << (i * lw));
        end
    endfunction

    task automatic op(input logic [127:0] s, input int sz, input bit wide, input bit sc,
                      input bit ng, input bit clr, input string tag);
        logic [127:0] r;
        bit sat, bad;
        @(negedge clk);
        src = s; size_code = 2'(sz); wide_mode = wide; scalar_sel = sc;
        neg_sel = ng; clr_sticky = clr; in_valid = 1'b1;
        model(s, sz, wide, sc, ng, r, sat, bad);
        model_sticky = (model_sticky && !clr) || sat;
        q_res.push_back(r);
        q_err.push_back(bad);
        q_st.push_back(32'(model_sticky) << 27);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            clr_sticky = 1'b0;
        end
    endtask

    // Monitor: samples 2 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst) begin
                if (out_valid) begin
                    if (q_res.size() == 0) begin
                        check(0, "R10 unexpected out_valid", 128'(out_valid), 128'(0));
                    end else begin
                        logic [127:0] er;
                        bit ee;
                        logic [31:0] es;
                        string t;
                        er = q_res.pop_front();
                        ee = q_err.pop_front();
                        es = q_st.pop_front();
                        t  = q_tag.pop_front();
                        check(result == er, {t, " result"}, result, er);
                        check(err == ee, {t, " R8/R10 err"}, 128'(err), 128'(ee));
                        check(status == es, {t, " R5 status"}, 128'(status), 128'(es));
                    end
                end else if (q_res.size() != 0) begin
                    check(0, "R10 missing out_valid", 128'(0), 128'(1));
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: state after reset
        check(out_valid == 0, "R9 out_valid after reset", 128'(out_valid), 0);
        check(status == 0, "R9 status after reset", 128'(status), 0);

        // R1 R2 R3: 16-bit abs, wide vector, no saturation
        op(128'h0001_FFFF_7FFF_8001_1234_EDCC_0000_FFFE, 1, 1, 0, 0, 0, "R1 R3 abs16 wide");
        // R7 R2: 32-bit negate in 64-bit mode, upper half zero
        op(128'hDEAD_BEEF_1234_5678_0000_0005_FFFF_FFF0, 2, 0, 0, 1, 0, "R7 R2 neg32 narrow");
        // R4: 8-bit abs with most negative lanes
        op(128'h0001_FF80_7F81_10F0_55AA_C33C_E020_FE02, 0, 1, 0, 0, 0, "R4 abs8 wide");
        // R5: later non-saturating op keeps sticky
        op(128'h1111_2222_3333_4444_5555_6666_7777_8888 ^ 128'h8888, 1, 1, 0, 1, 0, "R5 neg16 keep");
        idle(2);

        // R6: clear
        @(negedge clk);
        clr_sticky = 1'b1;
        model_sticky = 0;
        @(negedge clk);
        clr_sticky = 1'b0;
        @(negedge clk);
        check(status[27] == 0, "R6 clear", 128'(status), 0);

        // R1 R4: 64-bit wide negate with most negative in lane 1
        op(128'h8000_0000_0000_0000_0000_0000_0000_0003, 3, 1, 0, 1, 0, "R4 neg64 wide");
        // R6: clear plus saturation in the same cycle, saturation wins
        op(128'h0000_0000_0000_0000_0000_0000_0000_0080, 0, 1, 1, 0, 1, "R6 clear+sat");
        // R6: clear plus non-saturating op clears
        op(128'h0000_0000_0000_0000_0000_0000_0000_0005, 0, 1, 1, 1, 1, "R6 clear no sat");
        // R2 R7: scalar 8-bit abs in wide mode, only lane 0
        op(128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FF85, 0, 1, 1, 0, 0, "R2 R7 scalar8");
        // R7: scalar 64-bit negate in narrow mode
        op(128'hAAAA_AAAA_AAAA_AAAA_0000_0000_0000_0007, 3, 0, 1, 1, 0, "R7 scalar64");
        // R8: illegal vector 64-bit lanes in 64-bit register, with min value present
        op(128'h0000_0000_0000_0000_8000_0000_0000_0000, 3, 0, 0, 0, 0, "R8 illegal");
        // R1 R3: 32-bit abs wide, mixed signs
        op(128'h8000_0001_FFFF_FFFF_7FFF_FFFF_0000_0000, 2, 1, 0, 0, 0, "R1 R3 abs32 wide");
        // R2: 8-bit vector in narrow mode processes 8 lanes
        op(128'h0102_0304_0506_0708_F1F2_F3F4_F5F6_F7F8, 0, 0, 0, 1, 0, "R2 neg8 narrow");
        idle(3);

        // R9: reset mid-run clears sticky (set it first)
        op(128'h0000_0000_0000_0000_0000_0000_0000_8000, 1, 1, 1, 0, 0, "R4 scalar16 min");
        idle(2);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_sticky = 0;
        @(negedge clk);
        check(status == 0, "R9 status after mid reset", 128'(status), 0);
        check(out_valid == 0, "R9 out_valid after mid reset", 128'(out_valid), 0);

        idle(3);
        check(q_res.size() == 0, "R10 all results seen", 128'(q_res.size()), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule